// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 38-bit virtual byte address into a physical address. It does this by reading two 32-bit entries from a page table held in ordinary memory. The virtual address splits into three parts:

- a 12-bit directory index in the top bits,
- a 12-bit table index in the middle,
- a 14-bit offset inside a 16 KB page.

Each table holds 4096 four-byte entries, so one table fills exactly one page.

Each entry carries a 24-bit frame number in bits [31:8] and eight control bits in bits [7:0]. Bit 0 marks the entry present and bit 1 marks the page writable. Bit 2 is the user flag, bit 3 the accessed flag and bit 4 the dirty flag; bits [7:5] are reserved. The walker reads only bits 0 and 1 and passes the whole control byte out unchanged, so that a translation cache beside it can be filled.

The walker takes one request at a time and captures the directory base frame when it accepts the request. It issues its reads on a valid/ready request channel and takes each returned word on a separate valid strobe. The memory may stall either channel for any number of cycles. The result (physical address, fault code and control byte) is held until the consumer takes it.

Top module: `ptw_walker`

## Requirements
- R1: A synchronous active-low reset returns the walker to idle within one clock. After reset `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0. A walk in progress or a result not yet taken is discarded.
- R2: The first read of a walk goes to the address {base frame, vaddr[37:26], 2'b00}. The base frame is the value of `dir_base_frame` captured in the cycle the request is accepted.
- R3: When the directory entry has bit 0 set, the second read goes to the address {directory entry[31:8], vaddr[25:14], 2'b00}.
- R4: When the table entry has bit 0 set and the access is allowed, the result has fault code 0 and physical address {table entry[31:8], vaddr[13:0]}. `rsp_ctrl` carries table entry[7:0].
- R5: A directory entry with bit 0 clear ends the walk after that single read. The result has fault code 1, physical address 0, and `rsp_ctrl` equal to directory entry[7:0].
- R6: A table entry with bit 0 clear gives fault code 2 and physical address 0, with `rsp_ctrl` equal to table entry[7:0].
- R7: A write request to a present table entry whose bit 1 is clear gives fault code 3 and physical address 0. A read request to that same entry gives fault code 0.
- R8: `req_ready` is low from the cycle after a request is accepted until the result is taken. A `req_valid` seen while the walker is busy has no effect.
- R9: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. At most one read is outstanding at any time.
- R10: `rsp_valid` rises one clock after the final entry word arrives. The result fields then hold steady until `rsp_ready` is seen, after which the walker is idle.
- R11: A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_base_frame | input | 24 | Frame number of the page directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 38 | Virtual byte address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 38 | Physical byte address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 directory absent, 2 table entry absent, 3 write to read-only page |
| rsp_ctrl | output | 8 | Control byte of the last entry read |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 38 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Returned entry word is valid |
| mem_rsp_data | input | 32 | Returned entry word |

## Verification
The hardest situations to reach are a reset that lands while a read is outstanding and a reset that lands while a result is held back by the consumer. In both cases the memory, or the consumer, would otherwise still finish the walk. The bench reaches them with marked requests. The memory model holds back the reply to a marked request, and the consumer model refuses the result for another. Reset is pulsed at exactly that point, and the very next request must then walk cleanly. Stray response pulses between reads and `req_valid` pulses during a walk are mixed in throughout to show that both are ignored.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes the fault encoding below is visible to consumers as a 2-bit code.
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_DIR_ABSENT = 2'd1,
        FLT_TBL_ABSENT = 2'd2,
        FLT_READ_ONLY  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } walk_state_e;

    // Control-bit positions inside an entry's low byte.
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;

endpackage

// File: rtl/ptw_addr_gen.sv
// Forms the byte address of a table entry from a table frame and an index.
// Assumes entries are 2**GRAN_W bytes and tables are frame aligned.
module ptw_addr_gen #(
    parameter int FRAME_W = 24,
    parameter int IDX_W   = 12,
    parameter int GRAN_W  = 2
) (
    input  logic [FRAME_W-1:0]              frame,
    input  logic [IDX_W-1:0]                index,
    output logic [FRAME_W+IDX_W+GRAN_W-1:0] addr
);

    // Concatenate frame, index and the zero byte-in-entry bits.
    assign addr = {frame, index, {GRAN_W{1'b0}}};

endmodule

// File: rtl/ptw_entry_eval.sv
// Decodes a fetched entry into frame, control byte and a fault code.
// Assumes leaf=1 for a page-table entry and leaf=0 for a directory entry;
// the write permission is judged only at the leaf level.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int CTRL_W  = 8
) (
    input  logic [FRAME_W+CTRL_W-1:0] entry,
    input  logic                      leaf,
    input  logic                      write,
    output fault_e                    fault,
    output logic [FRAME_W-1:0]        frame,
    output logic [CTRL_W-1:0]         ctrl
);

    logic present;
    logic writable;

    assign frame    = entry[FRAME_W+CTRL_W-1:CTRL_W];
    assign ctrl     = entry[CTRL_W-1:0];
    assign present  = entry[BIT_PRESENT];
    assign writable = entry[BIT_WRITABLE];

    // Classify the entry: absent at either level, or a blocked write.
    always_comb begin
        if (!present)
            fault = leaf ? FLT_TBL_ABSENT : FLT_DIR_ABSENT;
        else if (leaf && write && !writable)
            fault = FLT_READ_ONLY;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker.
// Accepts one translation at a time, reads the directory entry, then
// (if present) the table entry, and holds the result until taken.
// Assumes DIR_W <= TBL_W and that a table fills one page, i.e.
// OFF_W - TBL_W is the log2 of the entry size in bytes.
// Assumes each memory response arrives at least one cycle after its request.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter  int DIR_W   = 12,
    parameter  int TBL_W   = 12,
    parameter  int OFF_W   = 14,
    parameter  int FRAME_W = 24,
    parameter  int CTRL_W  = 8,
    localparam int VA_W    = DIR_W + TBL_W + OFF_W,
    localparam int PA_W    = FRAME_W + OFF_W,
    localparam int ENTRY_W = FRAME_W + CTRL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] dir_base_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic [CTRL_W-1:0]  rsp_ctrl,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data
);

    localparam int GRAN_W = OFF_W - TBL_W;

    walk_state_e        state_q;
    logic [VA_W-1:0]    vaddr_q;
    logic               write_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] pde_frame_q;
    logic [PA_W-1:0]    paddr_q;
    fault_e             fault_q;
    logic [CTRL_W-1:0]  ctrl_q;

    logic               dir_phase;
    logic [FRAME_W-1:0] frame_sel;
    logic [TBL_W-1:0]   index_sel;
    fault_e             ev_fault;
    logic [FRAME_W-1:0] ev_frame;
    logic [CTRL_W-1:0]  ev_ctrl;

    // Pick the table frame and index for the level being read.
    assign dir_phase = (state_q == ST_DIR_REQ) || (state_q == ST_DIR_WAIT);
    assign frame_sel = dir_phase ? base_q : pde_frame_q;
    assign index_sel = dir_phase ? TBL_W'(vaddr_q[VA_W-1 -: DIR_W])
                                 : vaddr_q[OFF_W +: TBL_W];

    ptw_addr_gen #(
        .FRAME_W (FRAME_W),
        .IDX_W   (TBL_W),
        .GRAN_W  (GRAN_W)
    ) u_addr_gen (
        .frame (frame_sel),
        .index (index_sel),
        .addr  (mem_req_addr)
    );

    ptw_entry_eval #(
        .FRAME_W (FRAME_W),
        .CTRL_W  (CTRL_W)
    ) u_entry_eval (
        .entry (mem_rsp_data),
        .leaf  (state_q == ST_TBL_WAIT),
        .write (write_q),
        .fault (ev_fault),
        .frame (ev_frame),
        .ctrl  (ev_ctrl)
    );

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_fault     = fault_q;
    assign rsp_ctrl      = ctrl_q;

    // Sequence the walk through its request, wait and result phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     if (req_valid) state_q <= ST_DIR_REQ;
                ST_DIR_REQ:  if (mem_req_ready) state_q <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rsp_valid)
                                 state_q <= (ev_fault == FLT_NONE) ? ST_TBL_REQ : ST_DONE;
                ST_TBL_REQ:  if (mem_req_ready) state_q <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rsp_valid) state_q <= ST_DONE;
                ST_DONE:     if (rsp_ready) state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request, the directory frame and the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            write_q     <= 1'b0;
            base_q      <= '0;
            pde_frame_q <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
            ctrl_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                write_q <= req_write;
                base_q  <= dir_base_frame;
            end
            if (state_q == ST_DIR_WAIT && mem_rsp_valid) begin
                pde_frame_q <= ev_frame;
                if (ev_fault != FLT_NONE) begin
                    paddr_q <= '0;
                    fault_q <= ev_fault;
                    ctrl_q  <= ev_ctrl;
                end
            end
            if (state_q == ST_TBL_WAIT && mem_rsp_valid) begin
                paddr_q <= (ev_fault == FLT_NONE) ? {ev_frame, vaddr_q[OFF_W-1:0]} : '0;
                fault_q <= ev_fault;
                ctrl_q  <= ev_ctrl;
            end
        end
    end

endmodule

// File: rtl/ptw_walker_checker.sv
// Protocol and result checks for ptw_walker, attached with bind.
// Tracks the read count and the captured write flag and offset per walk.
module ptw_walker_checker #(
    parameter  int DIR_W   = 12,
    parameter  int TBL_W   = 12,
    parameter  int OFF_W   = 14,
    parameter  int FRAME_W = 24,
    parameter  int CTRL_W  = 8,
    localparam int PA_W    = FRAME_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [OFF_W-1:0]  req_off,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [1:0]        rsp_fault,
    input logic [CTRL_W-1:0] rsp_ctrl,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr
);

    logic [1:0]       rd_cnt;
    logic             wr_cap;
    logic [OFF_W-1:0] off_cap;

    // Record per-walk facts seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            wr_cap  <= 1'b0;
            off_cap <= '0;
        end else begin
            if (req_valid && req_ready) begin
                rd_cnt  <= '0;
                wr_cap  <= req_write;
                off_cap <= req_off;
            end else if (mem_req_valid && mem_req_ready) begin
                rd_cnt <= rd_cnt + 2'd1;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_req_valid));

    assert_second_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd1) |-> rd_cnt == 2'd2);

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_cap);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |-> (rd_cnt == 2'd1 && rsp_paddr == '0));

    assert_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd3) |-> wr_cap);

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    assert_mreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_ctrl)));

endmodule

bind ptw_walker ptw_walker_checker #(
    .DIR_W   (DIR_W),
    .TBL_W   (TBL_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W),
    .CTRL_W  (CTRL_W)
) u_ptw_walker_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_ctrl      (rsp_ctrl),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/ptw_walker_bench.sv
// Cycle-level reference bench for ptw_walker: behavioural memory,
// consumer and walk model, compared against the ports every clock.
module ptw_walker_bench;

    typedef struct {
        logic [37:0] va;
        logic        wr;
        int          kill;   // 1: reset while a read is outstanding, 2: reset while result held
        int          mhold;  // cycles the memory holds back each read request
        int          rhold;  // cycles the consumer holds back the result
    } req_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] dir_base_frame;
    logic        req_valid;
    logic        req_ready;
    logic [37:0] req_vaddr;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [37:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [7:0]  rsp_ctrl;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [37:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .dir_base_frame(dir_base_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_ctrl(rsp_ctrl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #10 clk = ~clk;

    logic [31:0] mem_words [logic [37:0]];
    req_t        reqs [$];
    req_t        cur;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;

    // Reference model state
    bit          busy, outstanding, result_out, just_reset, spur_seen, deliver, finished;
    int          issued, needed, delay, mwait, rwait;
    logic [37:0] ea0, ea1, ep;
    logic [31:0] ed0, ed1;
    logic [1:0]  ef;
    logic [7:0]  ec;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd(input logic [37:0] a);
        return mem_words.exists(a) ? mem_words[a] : 32'h0;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Expected walk computed from the requirements (R2..R7).
    task automatic predict(input req_t r);
        ea0 = {dir_base_frame, r.va[37:26], 2'b00};
        ed0 = rd(ea0);
        if (!ed0[0]) begin
            needed = 1; ef = 2'd1; ep = '0; ec = ed0[7:0];
        end else begin
            needed = 2;
            ea1 = {ed0[31:8], r.va[25:14], 2'b00};
            ed1 = rd(ea1);
            ec  = ed1[7:0];
            if (!ed1[0])                begin ef = 2'd2; ep = '0; end
            else if (r.wr && !ed1[1])   begin ef = 2'd3; ep = '0; end
            else                        begin ef = 2'd0; ep = {ed1[31:8], r.va[13:0]}; end
        end
    endtask

    task automatic step();
        string tg;
        bit exp_mv;
        // (a) compare the ports against the model
        tg = just_reset ? "R1" : "R8";
        chk(req_ready === !busy, tg, "req_ready", req_ready, !busy);
        exp_mv = busy && !outstanding && (issued < needed);
        chk(mem_req_valid === exp_mv, just_reset ? "R1" : "R9", "mem_req_valid", mem_req_valid, exp_mv);
        if (mem_req_valid && exp_mv) begin
            if (issued == 0) chk(mem_req_addr === ea0, "R2", "directory entry address", mem_req_addr, ea0);
            else             chk(mem_req_addr === ea1, "R3", "table entry address", mem_req_addr, ea1);
        end
        chk(rsp_valid === result_out, just_reset ? "R1" : "R10", "rsp_valid", rsp_valid, result_out);
        if (rsp_valid && result_out) begin
            case (ef)
                2'd0: tg = (!cur.wr && !ed1[1]) ? "R7" : "R4";
                2'd1: tg = "R5";
                2'd2: tg = "R6";
                default: tg = "R7";
            endcase
            chk(rsp_fault === ef, tg, "rsp_fault", rsp_fault, ef);
            chk(rsp_paddr === ep, tg, "rsp_paddr", rsp_paddr, ep);
            chk(rsp_ctrl === ec, tg, "rsp_ctrl", rsp_ctrl, ec);
            if (spur_seen) chk(rsp_paddr === ep && rsp_fault === ef, "R11",
                               "result after stray response", rsp_paddr, ep);
        end
        just_reset = 0;

        // (b) drive inputs for the next edge
        rst_n = 1'b1;
        deliver = 0;
        if (busy && cur.kill == 1 && outstanding) begin rst_n = 1'b0; cur.kill = 0; end
        if (busy && cur.kill == 2 && result_out)  begin rst_n = 1'b0; cur.kill = 0; end
        if (!rst_n) begin
            req_valid = 1'b0;
        end else if (!busy && reqs.size() > 0) begin
            cur = reqs.pop_front();
            req_valid = 1'b1; req_vaddr = cur.va; req_write = cur.wr;
        end else if (busy) begin
            req_valid = 1'($urandom % 2);            // R8: must be ignored
            req_vaddr = {$urandom, 6'h2A}; req_write = 1'($urandom % 2);
        end else begin
            req_valid = 1'b0;
        end
        if (mem_req_valid && mwait < cur.mhold) begin mem_req_ready = 1'b0; mwait++; end
        else if (mem_req_valid) mem_req_ready = 1'b1;
        else mem_req_ready = 1'($urandom % 2);
        if (outstanding && delay == 0) begin
            deliver = 1; mem_rsp_valid = 1'b1;
            mem_rsp_data = (issued == 1) ? ed0 : ed1;
        end else if (!outstanding && ($urandom % 5 == 0)) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = $urandom;   // R11 stray pulse
            if (busy) spur_seen = 1;
        end else begin
            mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        end
        if (rsp_valid && (rwait < cur.rhold || cur.kill == 2)) begin rsp_ready = 1'b0; rwait++; end
        else if (rsp_valid) rsp_ready = 1'b1;
        else rsp_ready = 1'($urandom % 2);

        // (c) advance the model to the state after the next edge
        if (!rst_n) begin
            busy = 0; outstanding = 0; result_out = 0; issued = 0; needed = 0;
            just_reset = 1;
        end else begin
            if (req_valid && req_ready) begin
                predict(cur);
                busy = 1; issued = 0; outstanding = 0; mwait = 0; rwait = 0; spur_seen = 0;
            end
            if (mem_req_valid && mem_req_ready) begin
                issued++; outstanding = 1; delay = int'($urandom % 4); mwait = 0;
            end else if (deliver) begin
                outstanding = 0;
                if (issued == needed) result_out = 1;
            end else if (outstanding) begin
                delay--;
            end
            if (rsp_valid && rsp_ready && result_out) begin
                busy = 0; result_out = 0;
                if (reqs.size() == 0) finished = 1;
            end
        end
    endtask

    function automatic req_t mk(input logic [11:0] d, input logic [11:0] t, input logic [13:0] o,
                                input logic w, input int k, input int mh, input int rh);
        req_t r;
        r.va = {d, t, o}; r.wr = w; r.kill = k; r.mhold = mh; r.rhold = rh;
        return r;
    endfunction

    initial begin
        dir_base_frame = 24'h0C0123;
        // Directory 0x005 -> table in frame 0x00A000; directory 0xFFF -> frame 0xFFFFFF
        mem_words[{24'h0C0123, 12'h005, 2'b00}] = {24'h00A000, 8'h07};
        mem_words[{24'h00A000, 12'h010, 2'b00}] = {24'hBEEF12, 8'h03};
        mem_words[{24'h00A000, 12'h011, 2'b00}] = {24'h000777, 8'h05};
        mem_words[{24'h00A000, 12'h012, 2'b00}] = {24'h345678, 8'h1A};
        mem_words[{24'h0C0123, 12'hFFF, 2'b00}] = {24'hFFFFFF, 8'h01};
        mem_words[{24'hFFFFFF, 12'hFFF, 2'b00}] = {24'h123456, 8'h1F};
        mem_words[{24'h0C0123, 12'h000, 2'b00}] = {24'hABCDEF, 8'hE0};

        reqs.push_back(mk(12'h005, 12'h010, 14'h0000, 0, 0, 0, 0));  // R4
        reqs.push_back(mk(12'h005, 12'h010, 14'h3FFF, 1, 0, 0, 0));  // R4 writable
        reqs.push_back(mk(12'h005, 12'h011, 14'h1234, 0, 0, 1, 1));  // R7 read ok
        reqs.push_back(mk(12'h005, 12'h011, 14'h1234, 1, 0, 0, 2));  // R7 write fault
        reqs.push_back(mk(12'h005, 12'h012, 14'h0001, 0, 0, 0, 0));  // R6
        reqs.push_back(mk(12'h000, 12'h0AA, 14'h0ABC, 1, 0, 0, 0));  // R5 ctrl E0
        reqs.push_back(mk(12'hFFF, 12'hFFF, 14'h3FFF, 1, 0, 0, 0));  // R4 top corner
        reqs.push_back(mk(12'h7AB, 12'h001, 14'h0002, 0, 0, 0, 0));  // R5 absent
        reqs.push_back(mk(12'h005, 12'h010, 14'h0555, 0, 0, 12, 9)); // R9 R10 long stalls
        reqs.push_back(mk(12'h005, 12'h010, 14'h0777, 0, 1, 0, 0));  // R1 reset mid-read
        reqs.push_back(mk(12'hFFF, 12'hFFF, 14'h0001, 0, 2, 0, 0));  // R1 reset, result held
        reqs.push_back(mk(12'h005, 12'h011, 14'h0042, 1, 0, 0, 0));  // first walk after reset
        for (int i = 0; i < 24; i++) begin
            case ($urandom % 5)
                0: reqs.push_back(mk(12'h005, 12'h010, 14'($urandom), 1'($urandom), 0, int'($urandom % 4), int'($urandom % 4)));
                1: reqs.push_back(mk(12'h005, 12'h011, 14'($urandom), 1'($urandom), 0, int'($urandom % 4), int'($urandom % 4)));
                2: reqs.push_back(mk(12'h005, 12'h012, 14'($urandom), 1'($urandom), 0, 0, 1));
                3: reqs.push_back(mk(12'($urandom), 12'($urandom), 14'($urandom), 1'($urandom), 0, 1, 0));
                default: reqs.push_back(mk(12'hFFF, 12'hFFF, 14'($urandom), 1'($urandom), 0, 2, 2));
            endcase
        end

        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        rsp_ready = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        busy = 0; outstanding = 0; result_out = 0; just_reset = 1; spur_seen = 0;
        finished = 0; issued = 0; needed = 0; delay = 0; mwait = 0; rwait = 0;
        cur = mk(12'h0, 12'h0, 14'h0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        while (!finished) begin
            @(negedge clk);
            step();
        end
        repeat (3) begin
            @(negedge clk);
            step();
        end
        finish_run();
    end

    // Watchdog: a hung walk counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=all walks complete");
        finish_run();
    end

endmodule